// File: doc/BRIEF.md
# Dithered DAC Code Generator

This block turns a 16-bit sample into an 8-bit converter code that changes every clock. The upper byte of the sample picks a base level. The lower byte sets how many clocks in each 256-clock frame the code sits one step above that base. The code switches between the two neighbouring levels in a single pulse per frame, so a low-pass filter after the converter recovers an average with 16-bit resolution. The switching ripple is at clock/256.

A new sample can be offered with a load strobe at any time. It is held as pending and only takes effect at the next frame boundary, so a frame never mixes two samples. A frame-start pulse marks the first clock of every frame after the first one. Downstream logic can use it to pace sample delivery.

Top module: `dither_dac_gen`

## Requirements
- R1: After synchronous reset, `dac_code` is 128 (mid-scale), `frame_start` is low, and the effective sample is 0x8000. The first `frame_start` comes 256 clocks after reset is released.
- R2: Frames are exactly 256 clocks long. `frame_start` is high for one clock, in the first clock of each frame.
- R3: With base B = sample[15:8] and fraction F = sample[7:0], and clock index k = 0..255 within the frame (k = 0 is the `frame_start` clock), `dac_code` is B+1 when k < F and B otherwise. The raised level therefore forms one contiguous run at the start of the frame.
- R4: When B is 255, `dac_code` stays at 255 for the whole frame, whatever F is; it never wraps to 0.
- R5: A load during a frame does not change `dac_code` for the rest of that frame. The new sample applies from the next `frame_start` clock.
- R6: If several loads occur within one frame, the last one wins. This includes a load in the final clock (k = 255) of the frame.
- R7: In every clock, `dac_code` equals either B or min(B+1, 255) of the sample in effect.
- R8: A fraction of zero gives a constant `dac_code` of B for all 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_in | input | 16 | Sample: bits 15:8 base level, bits 7:0 high-level clock count |
| smp_load | input | 1 | Strobe that captures `smp_in` as the pending sample |
| dac_code | output | 8 | Registered code for the 8-bit converter |
| frame_start | output | 1 | One-clock pulse in the first clock of each frame |

## Verification
Every cycle, the assertions check several things:
- the frame pulse is one clock wide, lands on the counter's zero, and follows each counter wrap;
- the code only takes one of the two adjacent levels, clamps at full scale, and never rises again after it drops within a frame;
- the effective sample stays fixed between pulses, and a load in the wrap cycle is the one taken;
- the post-reset values.

Only the bench scenarios can show certain other properties:
- the exact run length for each fraction;
- the 256-clock spacing from reset;
- that a load placed mid-frame shows up one frame later with the right code pattern;
- that the last of several loads is the one that applies.

// File: rtl/dither_pkg.sv
// Package: shared default widths and helpers for the dithered DAC code generator.
// Assumes: level and fraction widths are at least 1 bit.
package dither_pkg;
    localparam int DEF_LEVEL_W = 8;
    localparam int DEF_FRAC_W  = 8;

    // Mid-scale code for a given width: MSB set, rest clear.
    function automatic logic [31:0] mid_scale(input int width);
        mid_scale = 32'd1 << (width - 1);
    endfunction
endpackage

// File: rtl/dither_frame_counter.sv
// Frame counter: free-running position counter over one dither frame.
// Gives the next position, a wrap flag in the last clock of a frame, and a
// registered frame-start pulse in the first clock of every later frame.
// Assumes: frame length is 2**FRAC_W clocks; reset is synchronous, active low.
module dither_frame_counter #(
    parameter int FRAC_W = dither_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [FRAC_W-1:0] pos_next,
    output logic              wrap,
    output logic              frame_start
);
    logic [FRAC_W-1:0] pos_q;

    // Next position and last-clock detect.
    always_comb begin
        pos_next = pos_q + 1'b1;
        wrap     = &pos_q;
    end

    // Position register and frame-start pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q       <= '0;
            frame_start <= 1'b0;
        end else begin
            pos_q       <= pos_next;
            frame_start <= wrap;
        end
    end

    p_pulse_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> frame_start);
    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    p_pulse_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (pos_q == '0));
endmodule

// File: rtl/dither_sample_hold.sv
// Sample hold: keeps a pending sample, updated by every load strobe, and an
// effective sample that copies the pending one only when 'take' is high.
// A load in the same clock as 'take' goes straight through.
// Assumes: synchronous active-low reset; reset value is mid-scale.
module dither_sample_hold #(
    parameter int SMP_W = dither_pkg::DEF_LEVEL_W + dither_pkg::DEF_FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SMP_W-1:0] din,
    input  logic             take,
    output logic [SMP_W-1:0] active_next,
    output logic [SMP_W-1:0] active_q
);
    localparam logic [SMP_W-1:0] RST_SMP = SMP_W'(dither_pkg::mid_scale(SMP_W));

    logic [SMP_W-1:0] pend_q;
    logic [SMP_W-1:0] pend_next;

    // Newest pending sample, and the effective sample for the next clock.
    always_comb begin
        pend_next   = load ? din : pend_q;
        active_next = take ? pend_next : active_q;
    end

    // Pending and effective sample registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= RST_SMP;
            active_q <= RST_SMP;
        end else begin
            pend_q   <= pend_next;
            active_q <= active_next;
        end
    end

    p_late_load_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && load) |=> (active_q == $past(din)));
endmodule

// File: rtl/dither_level_select.sv
// Level select: maps an effective sample and a frame position to a code.
// Gives base+1 (clamped at full scale) while position < fraction, else base.
// Assumes: sample = {base, fraction}, purely combinational.
module dither_level_select #(
    parameter int LEVEL_W = dither_pkg::DEF_LEVEL_W,
    parameter int FRAC_W  = dither_pkg::DEF_FRAC_W
) (
    input  logic [LEVEL_W+FRAC_W-1:0] sample,
    input  logic [FRAC_W-1:0]         pos,
    output logic [LEVEL_W-1:0]        code
);
    logic [LEVEL_W-1:0] base;
    logic [FRAC_W-1:0]  frac;
    logic [LEVEL_W-1:0] upper;

    // Split sample, form the clamped upper level, pick by position.
    always_comb begin
        base  = sample[LEVEL_W+FRAC_W-1 -: LEVEL_W];
        frac  = sample[FRAC_W-1:0];
        upper = (&base) ? base : base + 1'b1;
        code  = (pos < frac) ? upper : base;
    end
endmodule

// File: rtl/dither_dac_gen.sv
// Dithered DAC code generator (top): drives a LEVEL_W-bit converter code
// every clock, with PWM switching between two adjacent levels in each
// 2**FRAC_W-clock frame. Samples are applied only at frame boundaries.
// Assumes: synchronous active-low reset; the code is registered.
module dither_dac_gen #(
    parameter int LEVEL_W = dither_pkg::DEF_LEVEL_W,
    parameter int FRAC_W  = dither_pkg::DEF_FRAC_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LEVEL_W+FRAC_W-1:0] smp_in,
    input  logic                      smp_load,
    output logic [LEVEL_W-1:0]        dac_code,
    output logic                      frame_start
);
    localparam int SMP_W = LEVEL_W + FRAC_W;
    localparam logic [LEVEL_W-1:0] MID_CODE = LEVEL_W'(dither_pkg::mid_scale(LEVEL_W));

    logic [FRAC_W-1:0]  pos_next;
    logic               wrap;
    logic [SMP_W-1:0]   active_next;
    logic [SMP_W-1:0]   active_q;
    logic [LEVEL_W-1:0] code_next;
    logic [LEVEL_W-1:0] base_lvl;

    dither_frame_counter #(.FRAC_W(FRAC_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_next    (pos_next),
        .wrap        (wrap),
        .frame_start (frame_start)
    );

    dither_sample_hold #(.SMP_W(SMP_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (smp_load),
        .din         (smp_in),
        .take        (wrap),
        .active_next (active_next),
        .active_q    (active_q)
    );

    dither_level_select #(.LEVEL_W(LEVEL_W), .FRAC_W(FRAC_W)) u_sel (
        .sample (active_next),
        .pos    (pos_next),
        .code   (code_next)
    );

    // Base level of the sample in effect, for the checks below.
    always_comb base_lvl = active_q[SMP_W-1 -: LEVEL_W];

    // Output code register, aligned with the counter and sample registers.
    always_ff @(posedge clk) begin
        if (!rst_n) dac_code <= MID_CODE;
        else        dac_code <= code_next;
    end

    p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dac_code == MID_CODE && !frame_start));
    p_hold_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> $stable(active_q));
    p_adjacent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == base_lvl) || (dac_code == base_lvl + 1'b1) || (&base_lvl && &dac_code));
    p_full_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&base_lvl) |-> (&dac_code));
    p_single_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && $past(dac_code) == base_lvl && !(&base_lvl)) |-> (dac_code == base_lvl));
endmodule

// File: tb/dither_dac_gen_test.sv
`timescale 1ns/1ps
module dither_dac_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] smp_in = '0;
    logic        smp_load = 1'b0;
    logic [7:0]  dac_code;
    logic        frame_start;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dither_dac_gen uut (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_load(smp_load),
        .dac_code(dac_code), .frame_start(frame_start)
    );

    // {sample, low level, high level, run length}
    localparam logic [39:0] VEC [8] = '{
        {16'h4000, 8'h40, 8'h41, 8'd0},    // R8 zero fraction
        {16'h40FF, 8'h40, 8'h41, 8'd255},  // R3 longest run
        {16'h7F80, 8'h7F, 8'h80, 8'd128},  // R3 half
        {16'h0001, 8'h00, 8'h01, 8'd1},    // R3 single clock
        {16'hFF80, 8'hFF, 8'hFF, 8'd128},  // R4 saturation
        {16'hFFFF, 8'hFF, 8'hFF, 8'd255},  // R4 saturation
        {16'h0000, 8'h00, 8'h01, 8'd0},    // R8 zero code
        {16'h8040, 8'h80, 8'h81, 8'd64}    // R3 quarter
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse a load for one clock, starting at the current falling edge.
    task automatic pulse_load(input logic [15:0] v);
        smp_in   = v;
        smp_load = 1'b1;
        @(negedge clk);
        smp_load = 1'b0;
    endtask

    // Called at k=0 of a frame; checks all 256 codes and the pulse, ending at k=0
    // of the next frame. Optional loads at clocks la and lb (-1 = none).
    task automatic check_frame(input string tag, input logic [7:0] lo, input logic [7:0] hi,
                               input int run, input int la, input logic [15:0] va,
                               input int lb, input logic [15:0] vb);
        int bad_k = -1;
        int bad_act = 0;
        int bad_exp = 0;
        for (int k = 0; k < 256; k++) begin
            int e;
            e = (k < run) ? hi : lo;
            if ((dac_code != e || frame_start != (k == 0)) && bad_k < 0) begin
                bad_k = k; bad_act = dac_code; bad_exp = e;
            end
            if (k == la || k == lb) begin
                smp_in   = (k == la) ? va : vb;
                smp_load = 1'b1;
            end else begin
                smp_load = 1'b0;
            end
            @(negedge clk);
        end
        smp_load = 1'b0;
        if (bad_k >= 0) $display("  (%s first mismatch at clock %0d)", tag, bad_k);
        chk(tag, bad_act, bad_exp);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        chk("R1 reset code", dac_code, 128);
        chk("R1 reset frame_start", frame_start, 0);
        rst_n = 1'b1;
        n = 0;
        while (!frame_start && n < 400) begin
            if (dac_code != 8'd128) chk("R1 mid-scale before first frame", dac_code, 128);
            @(negedge clk);
            n++;
        end
        chk("R1 first frame_start delay", n, 256);

        // Table walk: load at k=0, skip one frame, check the following frame.
        for (int i = 0; i < 8; i++) begin
            pulse_load(VEC[i][39:24]);
            repeat (255) @(negedge clk);
            chk("R2 frame period", frame_start, 1);
            check_frame("R3 vector frame", VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]),
                        -1, '0, -1, '0);
            // Now at k=0 of the frame after the checked one.
            repeat (256) @(negedge clk);
        end

        // R5: establish 0x4000, then load 0xC0FF mid-frame at k=100.
        pulse_load(16'h4000);
        repeat (255) @(negedge clk);
        check_frame("R5 mid-frame load ignored", 8'h40, 8'h41, 0, 100, 16'hC0FF, -1, '0);
        check_frame("R5 load applied next frame", 8'hC0, 8'hC1, 255, 10, 16'h1111, 255, 16'h2280);
        check_frame("R6 last load wins at k=255", 8'h22, 8'h23, 128, -1, '0, -1, '0);
        chk("R2 pulse after frames", frame_start, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule